// File: doc/BRIEF.md
# Dual-Channel Disk Interrupt Gate

This block sits on an expansion card that carries two disk-drive channels. Each channel delivers a raw interrupt request. The block passes that request through a per-channel enable latch, shows the gated result as a status bit, and merges both gated requests into a single card interrupt line. Software controls the latches through access side effects. Any write to a channel's control address arms that channel. A read of the same address disarms it, and the read returns the latch state from just before the read.

The block also holds a byte-wide card-select register. Bit 0 of that register steers the one shared DMA path to channel 0 or channel 1, and bit 5 selects the alternate address space. A 4-bit card identity can be read as bit 0 of four bytes spaced four apart. Host software reads this identity at probe time to tell the dual-channel board (code 3) from other variants. On reset both latches are disarmed and the select register is cleared. Read data is registered and appears in the cycle after the read strobe.

Top module: `dual_chan_irq_gate`

## Requirements
- R1: After reset, both enable latches are 0, the select register is 0x00, `card_irq` is 0, `dma_chan` and `alt_space` are 0, and `bus_rdata` is 0x00.
- R2: A write of any data value to a channel's control address (0x880 for channel 0, 0xC80 for channel 1) sets that channel's enable latch and leaves the other channel's latch unchanged.
- R3: A read of a channel's control address clears that channel's enable latch. The returned byte holds the latch value from before the read in bit 0, and 0 in bits 7..1.
- R4: A read of a status address (0x8A4 for channel 0, 0xCA4 for channel 1) returns `raw_irq[ch] & enable[ch]` in bit 0 and 0 in bits 7..1. A status read does not change either latch.
- R5: `card_irq` is registered. In the cycle after each clock edge it equals the OR over both channels of `raw_irq[ch] & enable[ch]` as sampled at that edge.
- R6: The select register at address 0x000 stores the full written byte and reads it back unchanged. `dma_chan` follows bit 0 and `alt_space` follows bit 5. Writing 0x00 restores channel 0 routing and the normal address space.
- R7: Reads at 0x2280, 0x2284, 0x2288 and 0x228C return bits 0, 1, 2 and 3 of the card type code in bit 0, with 0 in bits 7..1. The default code is 3 (binary 0011).
- R8: A read of any unmapped address returns 0x00. A write to any unmapped address, or to a status or identity address, changes no latch and leaves the select register unchanged.
- R9: When a read and a write to the same control address occur in one cycle, the write wins and the channel ends up enabled.
- R10: Read data appears on `bus_rdata` one cycle after the read strobe. In the cycle after a cycle without a read strobe, `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 14 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| raw_irq | input | 2 | Raw interrupt request, one bit per channel |
| card_irq | output | 1 | Combined gated card interrupt |
| dma_chan | output | 1 | Channel the shared DMA path is routed to |
| alt_space | output | 1 | Alternate address space selected |

## Verification
The bench instantiates the gate with its default parameters: two channels, a 14-bit address, a channel stride of 0x400, a status offset of 0x24 and card type 3. With a stride of 0x400, the control and status addresses of the two channels differ in a single address bit, so a decoder that ignores that bit shows up as cross-talk between the channels. The type code 0011 is asymmetric, so reversing the order of the identity bits gives a different readback. With two channels, every mix of armed and raw states on the combined interrupt line can be reached in a few directed steps.

// File: rtl/dcig_pkg.sv
package dcig_pkg;

    // Source selected for the registered read data
    typedef enum logic [2:0] {
        RS_NONE = 3'd0,
        RS_SEL  = 3'd1,
        RS_CTRL = 3'd2,
        RS_STAT = 3'd3,
        RS_ID   = 3'd4
    } rd_src_e;

    // Bit positions inside the select register that drive outputs
    localparam int SEL_DMA_BIT = 0;
    localparam int SEL_ALT_BIT = 5;

    // Default register map
    localparam int DEF_SEL_ADDR  = 'h000;
    localparam int DEF_CTRL_BASE = 'h880;
    localparam int DEF_CH_STRIDE = 'h400;
    localparam int DEF_STAT_OFS  = 'h024;
    localparam int DEF_ID_BASE   = 'h2280;
    localparam int DEF_ID_STEP   = 4;

endpackage

// File: rtl/dcig_decode.sv
module dcig_decode
    import dcig_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int NUM_CH    = 2,
    parameter int SEL_ADDR  = DEF_SEL_ADDR,
    parameter int CTRL_BASE = DEF_CTRL_BASE,
    parameter int CH_STRIDE = DEF_CH_STRIDE,
    parameter int STAT_OFS  = DEF_STAT_OFS,
    parameter int ID_BASE   = DEF_ID_BASE,
    parameter int ID_STEP   = DEF_ID_STEP,
    parameter int ID_BITS   = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               sel_hit,
    output logic [NUM_CH-1:0]  ctrl_hit,
    output logic [NUM_CH-1:0]  stat_hit,
    output logic [ID_BITS-1:0] id_hit,
    output rd_src_e            src
);

    assign sel_hit = (addr == ADDR_W'(SEL_ADDR));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int CTRL_A = CTRL_BASE + c * CH_STRIDE;
        localparam int STAT_A = CTRL_A + STAT_OFS;
        assign ctrl_hit[c] = (addr == ADDR_W'(CTRL_A));
        assign stat_hit[c] = (addr == ADDR_W'(STAT_A));
    end

    for (genvar i = 0; i < ID_BITS; i++) begin : g_id
        assign id_hit[i] = (addr == ADDR_W'(ID_BASE + i * ID_STEP));
    end

    always_comb begin
        src = RS_NONE;
        if (sel_hit)
            src = RS_SEL;
        else if (|ctrl_hit)
            src = RS_CTRL;
        else if (|stat_hit)
            src = RS_STAT;
        else if (|id_hit)
            src = RS_ID;
    end

endmodule

// File: rtl/dcig_chan.sv
module dcig_chan (
    input  logic en_q,
    input  logic raw,
    input  logic ctrl_hit,
    input  logic rd,
    input  logic wr,
    output logic en_d,
    output logic pend
);

    // Gated request seen by status and the card line
    assign pend = raw & en_q;

    // Write arms, read disarms; a write in the same cycle takes priority
    always_comb begin
        en_d = en_q;
        if (ctrl_hit && wr)
            en_d = 1'b1;
        else if (ctrl_hit && rd)
            en_d = 1'b0;
    end

endmodule

// File: rtl/dcig_ident.sv
module dcig_ident #(
    parameter int ID_BITS   = 4,
    parameter int CARD_TYPE = 3
) (
    input  logic [ID_BITS-1:0] id_hit,
    output logic               id_bit
);

    localparam logic [ID_BITS-1:0] TYPE_V = ID_BITS'(CARD_TYPE);

    assign id_bit = |(id_hit & TYPE_V);

endmodule

// File: rtl/dual_chan_irq_gate.sv
module dual_chan_irq_gate
    import dcig_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 8,
    parameter int NUM_CH    = 2,
    parameter int SEL_ADDR  = DEF_SEL_ADDR,
    parameter int CTRL_BASE = DEF_CTRL_BASE,
    parameter int CH_STRIDE = DEF_CH_STRIDE,
    parameter int STAT_OFS  = DEF_STAT_OFS,
    parameter int ID_BASE   = DEF_ID_BASE,
    parameter int ID_STEP   = DEF_ID_STEP,
    parameter int ID_BITS   = 4,
    parameter int CARD_TYPE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] raw_irq,
    output logic              card_irq,
    output logic              dma_chan,
    output logic              alt_space
);

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [DATA_W-1:0] sel;
        logic [DATA_W-1:0] rdata;
        logic              irq;
    } state_t;

    state_t st_q, st_d;

    logic               sel_hit;
    logic [NUM_CH-1:0]  ctrl_hit;
    logic [NUM_CH-1:0]  stat_hit;
    logic [ID_BITS-1:0] id_hit;
    rd_src_e            src;
    logic               id_bit;
    logic [NUM_CH-1:0]  en_q;
    logic [NUM_CH-1:0]  en_next;
    logic [NUM_CH-1:0]  pend;

    assign en_q = st_q.en;

    dcig_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CH   (NUM_CH),
        .SEL_ADDR (SEL_ADDR),
        .CTRL_BASE(CTRL_BASE),
        .CH_STRIDE(CH_STRIDE),
        .STAT_OFS (STAT_OFS),
        .ID_BASE  (ID_BASE),
        .ID_STEP  (ID_STEP),
        .ID_BITS  (ID_BITS)
    ) u_decode (
        .addr    (bus_addr),
        .sel_hit (sel_hit),
        .ctrl_hit(ctrl_hit),
        .stat_hit(stat_hit),
        .id_hit  (id_hit),
        .src     (src)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dcig_chan u_chan (
            .en_q    (en_q[c]),
            .raw     (raw_irq[c]),
            .ctrl_hit(ctrl_hit[c]),
            .rd      (bus_rd),
            .wr      (bus_wr),
            .en_d    (en_next[c]),
            .pend    (pend[c])
        );
    end

    dcig_ident #(
        .ID_BITS  (ID_BITS),
        .CARD_TYPE(CARD_TYPE)
    ) u_ident (
        .id_hit(id_hit),
        .id_bit(id_bit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.en    = en_next;
        st_d.irq   = |pend;
        st_d.rdata = '0;
        if (bus_wr && sel_hit)
            st_d.sel = bus_wdata;
        if (bus_rd) begin
            unique case (src)
                RS_SEL:  st_d.rdata = st_q.sel;
                RS_CTRL: st_d.rdata = DATA_W'(|(ctrl_hit & st_q.en));
                RS_STAT: st_d.rdata = DATA_W'(|(stat_hit & pend));
                RS_ID:   st_d.rdata = DATA_W'(id_bit);
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign card_irq  = st_q.irq;
    assign dma_chan  = st_q.sel[SEL_DMA_BIT];
    assign alt_space = st_q.sel[SEL_ALT_BIT];

endmodule

// File: rtl/dcig_checker.sv
module dcig_checker #(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 8,
    parameter int NUM_CH    = 2,
    parameter int SEL_ADDR  = 0,
    parameter int CTRL_BASE = 'h880,
    parameter int CH_STRIDE = 'h400,
    parameter int STAT_OFS  = 'h24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] raw_irq,
    input logic [NUM_CH-1:0] en_q,
    input logic              card_irq,
    input logic              dma_chan
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0); // R10

    AST_CARD_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> card_irq == (|($past(raw_irq & en_q)))); // R5

    AST_DMA_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(SEL_ADDR)) |=> $stable(dma_chan)); // R6

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_BASE + c * CH_STRIDE);
        localparam logic [ADDR_W-1:0] SA = ADDR_W'(CTRL_BASE + c * CH_STRIDE + STAT_OFS);

        AST_CTRL_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == CA) |=> en_q[c]); // R2

        AST_CTRL_READ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !bus_wr && bus_addr == CA) |=> !en_q[c]); // R3

        AST_STAT_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            ((bus_rd || bus_wr) && bus_addr == SA) |=> $stable(en_q)); // R4
    end

endmodule

bind dual_chan_irq_gate dcig_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_CH   (NUM_CH),
    .SEL_ADDR (SEL_ADDR),
    .CTRL_BASE(CTRL_BASE),
    .CH_STRIDE(CH_STRIDE),
    .STAT_OFS (STAT_OFS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .raw_irq  (raw_irq),
    .en_q     (en_q),
    .card_irq (card_irq),
    .dma_chan (dma_chan)
);

// File: tb/dual_chan_irq_gate_test.sv
module dual_chan_irq_gate_test;

    localparam logic [13:0] A_SEL   = 14'h000;
    localparam logic [13:0] A_CTRL0 = 14'h880;
    localparam logic [13:0] A_CTRL1 = 14'hC80;
    localparam logic [13:0] A_STAT0 = 14'h8A4;
    localparam logic [13:0] A_STAT1 = 14'hCA4;
    localparam logic [13:0] A_ID    = 14'h2280;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  raw_irq = '0;
    logic        card_irq;
    logic        dma_chan;
    logic        alt_space;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dual_chan_irq_gate uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .raw_irq  (raw_irq),
        .card_irq (card_irq),
        .dma_chan (dma_chan),
        .alt_space(alt_space)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [13:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [13:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 card_irq", {7'd0, card_irq}, 8'h00);
        check("R1 dma_chan", {7'd0, dma_chan}, 8'h00);
        check("R1 alt_space", {7'd0, alt_space}, 8'h00);
        do_read(A_SEL, d);   check("R1 select", d, 8'h00);
        do_read(A_CTRL0, d); check("R1 ctrl0", d, 8'h00);
        do_read(A_CTRL1, d); check("R1 ctrl1", d, 8'h00);
    endtask

    task automatic t_arm();
        logic [7:0] d;
        raw_irq = 2'b11;
        do_write(A_CTRL0, 8'h5A);
        idle();
        check("R5 card_irq after arm", {7'd0, card_irq}, 8'h01);
        do_read(A_STAT0, d); check("R2 R4 stat0 armed", d, 8'h01);
        do_read(A_STAT1, d); check("R2 stat1 untouched", d, 8'h00);
        do_read(A_STAT0, d); check("R4 stat read no side effect", d, 8'h01);
        do_write(A_CTRL1, 8'h00);
        do_read(A_STAT1, d); check("R2 stat1 armed by zero write", d, 8'h01);
        do_read(A_STAT0, d); check("R2 stat0 kept", d, 8'h01);
    endtask

    task automatic t_disarm();
        logic [7:0] d;
        do_read(A_CTRL0, d); check("R3 ctrl0 returns prior state", d, 8'h01);
        do_read(A_STAT0, d); check("R3 stat0 after disarm", d, 8'h00);
        do_read(A_STAT1, d); check("R3 stat1 unaffected", d, 8'h01);
        do_read(A_CTRL1, d); check("R3 ctrl1 returns prior state", d, 8'h01);
        idle();
        check("R5 card_irq after disarm", {7'd0, card_irq}, 8'h00);
        do_read(A_CTRL0, d); check("R3 ctrl0 second read", d, 8'h00);
    endtask

    task automatic t_gate();
        logic [7:0] d;
        raw_irq = 2'b00;
        do_write(A_CTRL1, 8'hFF);
        idle();
        check("R5 armed but raw low", {7'd0, card_irq}, 8'h00);
        do_read(A_STAT1, d); check("R4 raw low stat1", d, 8'h00);
        raw_irq = 2'b10;
        idle(); idle();
        check("R5 ch1 raw high", {7'd0, card_irq}, 8'h01);
        raw_irq = 2'b01;
        idle(); idle();
        check("R5 ch0 raw on disarmed channel", {7'd0, card_irq}, 8'h00);
        do_read(A_STAT0, d); check("R4 raw high but disarmed", d, 8'h00);
        do_read(A_CTRL1, d); check("R3 clean up ch1", d, 8'h01);
        raw_irq = 2'b00;
    endtask

    task automatic t_select();
        logic [7:0] d;
        do_write(A_SEL, 8'hA7);
        do_read(A_SEL, d); check("R6 select readback", d, 8'hA7);
        check("R6 dma_chan bit0", {7'd0, dma_chan}, 8'h01);
        check("R6 alt_space bit5", {7'd0, alt_space}, 8'h01);
        do_write(A_SEL, 8'h01);
        check("R6 alt cleared", {7'd0, alt_space}, 8'h00);
        check("R6 dma stays ch1", {7'd0, dma_chan}, 8'h01);
        do_write(A_SEL, 8'h00);
        check("R6 restore default dma", {7'd0, dma_chan}, 8'h00);
        do_read(A_SEL, d); check("R6 restore default value", d, 8'h00);
    endtask

    task automatic t_ident();
        logic [7:0] d;
        for (int i = 0; i < 4; i++) begin
            do_read(A_ID + 14'(i * 4), d);
            check($sformatf("R7 identity bit %0d", i), d, {7'd0, (i < 2) ? 1'b1 : 1'b0});
        end
        do_read(A_ID + 14'd1, d); check("R8 read between identity bytes", d, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        do_write(A_SEL, 8'h20);
        do_write(14'h881, 8'hFF);
        do_write(14'h480, 8'hFF);
        do_write(A_STAT0, 8'hFF);
        do_write(A_ID, 8'hFF);
        do_read(A_CTRL0, d); check("R8 ctrl0 not armed by stray writes", d, 8'h00);
        do_read(A_CTRL1, d); check("R8 ctrl1 not armed by stray writes", d, 8'h00);
        do_read(A_SEL, d);   check("R8 select unchanged", d, 8'h20);
        do_read(14'h123, d); check("R8 unmapped read", d, 8'h00);
        do_read(A_ID, d);    check("R8 identity not writable", d, 8'h01);
        do_write(A_SEL, 8'h00);
    endtask

    task automatic t_rdwr();
        logic [7:0] d;
        bus_addr = A_CTRL0; bus_wdata = 8'h00; bus_rd = 1'b1; bus_wr = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        do_read(A_CTRL0, d); check("R9 write wins over read", d, 8'h01);
    endtask

    task automatic t_latency();
        logic [7:0] d;
        do_write(A_SEL, 8'h5C);
        do_read(A_SEL, d); check("R10 data one cycle after strobe", d, 8'h5C);
        idle();
        check("R10 rdata zero after idle", bus_rdata, 8'h00);
        do_write(A_SEL, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arm();
        t_disarm();
        t_gate();
        t_select();
        t_ident();
        t_unmapped();
        t_rdwr();
        t_latency();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule